// File: doc/BRIEF.md
# UART Transmit Holding Buffer

This block sits between a bus master and a serial transmitter. It takes the characters the master writes and passes them on, one at a time, to the serializer. It has two modes, and the FIFO-enable control input picks between them. In single-register mode there is one holding slot, and a new write replaces whatever is still pending. In FIFO mode a queue of configurable depth (16 by default) stores characters in arrival order. A write that arrives when the queue is full is dropped.

The master's write strobe carries a 32-bit word and a word index. That index selects one of sixteen aliased word locations, so that burst writes are possible. All sixteen locations reach the same buffer, and only the low byte of the word is kept. The transmitter sees the next byte and a byte-available flag. It takes that byte by raising its load request for a clock cycle. A line status byte reports in bit 5 whether the holding buffer is empty. Any change of the FIFO-enable input empties the buffer.

Top module: `uart_tx_hold`

## Requirements
- R1: The `line_stat` output carries the holding-empty flag in bit 5. That bit is 1 exactly when no byte is pending, and the other seven bits are always 0. After reset `line_stat` is 8'h20 and `tx_avail` is 0.
- R2: Single-register mode is selected by `fifo_en`=0. There, a write stores `wr_data[7:0]`. From the following clock cycle `tx_byte` shows that byte, `tx_avail` is 1 and `line_stat` bit 5 is 0.
- R3: In single-register mode, a write that arrives while a byte is still pending replaces that byte.
- R4: In single-register mode, a clock edge with `ld_req`=1 and a byte pending removes that byte, and holding-empty sets. If a write arrives at the same edge, the new byte stays pending.
- R5: FIFO mode is selected by `fifo_en`=1. There, up to DEPTH (16) bytes are accepted. Fullness is judged before the edge, so a write at an edge where DEPTH bytes are held is discarded and the queued contents stay unchanged.
- R6: In FIFO mode, bytes leave in the order they were written. Each clock edge with `ld_req`=1 and a byte pending removes exactly one byte, and `tx_byte` then shows the next one.
- R7: In FIFO mode, holding-empty sets and `tx_avail` clears when the last queued byte is taken.
- R8: The value of `wr_addr` (any of the 16 aliases) and `wr_data[31:8]` have no effect on what is stored.
- R9: At the first clock edge where `fifo_en` differs from its value at the previous edge, all pending data is discarded and holding-empty sets. A write or load at that edge is ignored.
- R10: A load request while nothing is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-register mode |
| wr_en | input | 1 | Bus write strobe, one character per cycle high |
| wr_addr | input | 4 | Word index among the 16 aliased locations (ignored) |
| wr_data | input | 32 | Bus write word; only bits 7:0 are kept |
| ld_req | input | 1 | Transmitter load request, one byte taken per cycle high |
| tx_byte | output | 8 | Next byte for the transmitter |
| tx_avail | output | 1 | A byte is pending |
| line_stat | output | 8 | Line status byte, bit 5 = holding empty |

## Verification
The assertions assume that `fifo_en` is a static control that changes only now and then, and they mark every edge where it has just changed as a flush edge. Each property that looks one cycle ahead treats a mode change in between as an allowed exception. The properties also assume that `ld_req` is high only when the transmitter actually wants a byte. The bench drives every input half a cycle away from the active edge. It changes `fifo_en` only between directed scenarios, or deliberately together with a write to check that the write is ignored. It raises `ld_req` for exactly one cycle per byte it wants.

// File: rtl/uart_thb_pkg.sv
// Package: shared constants for the UART transmit holding buffer.
// Assumes: the line status byte is 8 bits wide and its holding-empty flag
// sits at bit 5, where the status decoder expects it.
package uart_thb_pkg;
    localparam int LSR_W        = 8;
    localparam int LSR_EMPTY_IX = 5;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_FIFO   = 1'b1
    } thb_mode_e;
endpackage

// File: rtl/thb_mode_ctl.sv
// Module: thb_mode_ctl
// Follows the FIFO-enable control and raises a flush for the one clock edge
// at which the input differs from its value at the previous edge.
// Assumes: fifo_en is a quasi-static control input.
module thb_mode_ctl
    import uart_thb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_en,
    output thb_mode_e mode,
    output logic      flush
);
    logic en_q;

    // Purpose: remember the enable as sampled at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    // Purpose: decode the mode and the mode-change flush.
    always_comb begin
        mode  = fifo_en ? MODE_FIFO : MODE_SINGLE;
        flush = (fifo_en != en_q);
    end
endmodule

// File: rtl/thb_single.sv
// Module: thb_single
// One-character holding register for single-register mode. A write always
// replaces the stored byte, and a load with no write at the same edge empties it.
// Assumes: act is low while the other mode is selected.
module thb_single #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              flush,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ld,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    // Purpose: store, overwrite, hand off or flush the single character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (act) begin
            if (wr) begin
                data_q  <= wdata;
                valid_q <= 1'b1;
            end else if (ld) begin
                valid_q <= 1'b0;
            end
        end
    end

    // Purpose: drive the outputs from the register.
    always_comb begin
        rdata = data_q;
        valid = valid_q;
    end
endmodule

// File: rtl/thb_fifo.sv
// Module: thb_fifo
// Circular queue for FIFO mode. A write is accepted only if fewer than DEPTH
// entries are held before the edge, and a load pops the head if one exists.
// Assumes: DEPTH >= 2, and act is low while the other mode is selected.
module thb_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       act,
    input  logic                       flush,
    input  logic                       wr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       ld,
    output logic [DATA_W-1:0]          rdata,
    output logic                       valid,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              push, pop;
    logic [DATA_W-1:0] ent_rd [DEPTH];

    // Purpose: decide which queue operations take effect at this edge.
    always_comb begin
        push = act && !flush && wr && (cnt_q < CNT_W'(DEPTH));
        pop  = act && !flush && ld && (cnt_q != '0);
    end

    // Purpose: one storage entry per queue slot, written when the tail points at it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DATA_W-1:0] ent_q;

        // Purpose: capture the pushed byte into this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                              ent_q <= '0;
            else if (push && wr_ptr_q == PTR_W'(i))  ent_q <= wdata;
        end

        assign ent_rd[i] = ent_q;
    end

    // Purpose: advance the pointers and the occupancy count, or clear them on a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Purpose: present the head entry and the occupancy.
    always_comb begin
        rdata = ent_rd[rd_ptr_q];
        valid = (cnt_q != '0);
        count = cnt_q;
    end
endmodule

// File: rtl/uart_tx_hold.sv
// Module: uart_tx_hold
// Transmit holding buffer of a UART. Bus writes to any of ALIAS_N aliased
// word locations deliver their low byte either to a one-entry holding
// register or to a DEPTH-entry queue, depending on fifo_en. The transmitter
// takes one byte per cycle of ld_req. Bit 5 of line_stat reports holding-empty.
// Assumes: ld_req is only raised by the transmitter when it wants a byte.
module uart_tx_hold
    import uart_thb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BUS_W   = 32,
    parameter int DEPTH   = 16,
    parameter int ALIAS_N = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic                       wr_en,
    input  logic [$clog2(ALIAS_N)-1:0] wr_addr,
    input  logic [BUS_W-1:0]           wr_data,
    input  logic                       ld_req,
    output logic [DATA_W-1:0]          tx_byte,
    output logic                       tx_avail,
    output logic [LSR_W-1:0]           line_stat
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    thb_mode_e         mode;
    logic              mode_flush;
    logic [DATA_W-1:0] wbyte;
    logic [DATA_W-1:0] sgl_byte, fifo_byte;
    logic              sgl_valid, fifo_valid;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              unused_bus;

    // Purpose: keep only the character byte; the alias index and the upper bits are dropped.
    always_comb begin
        wbyte      = wr_data[DATA_W-1:0];
        unused_bus = ^{wr_addr, wr_data[BUS_W-1:DATA_W]};
    end

    thb_mode_ctl u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .mode    (mode),
        .flush   (mode_flush)
    );

    thb_single #(.DATA_W(DATA_W)) u_single (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (mode == MODE_SINGLE),
        .flush (mode_flush),
        .wr    (wr_en),
        .wdata (wbyte),
        .ld    (ld_req),
        .rdata (sgl_byte),
        .valid (sgl_valid)
    );

    thb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (mode == MODE_FIFO),
        .flush (mode_flush),
        .wr    (wr_en),
        .wdata (wbyte),
        .ld    (ld_req),
        .rdata (fifo_byte),
        .valid (fifo_valid),
        .count (fifo_cnt)
    );

    // Purpose: select the active store and build the line status byte.
    always_comb begin
        tx_byte   = (mode == MODE_FIFO) ? fifo_byte  : sgl_byte;
        tx_avail  = (mode == MODE_FIFO) ? fifo_valid : sgl_valid;
        line_stat = '0;
        line_stat[LSR_EMPTY_IX] = !tx_avail;
    end
endmodule

// File: rtl/thb_checker.sv
// Module: thb_checker
// Properties for uart_tx_hold, attached with the bind below.
// Assumes: the flush input is the top's mode-change flush and fifo_cnt is the
// queue occupancy.
module thb_checker #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_en,
    input logic                       wr_en,
    input logic [31:0]                wr_data,
    input logic                       ld_req,
    input logic [7:0]                 tx_byte,
    input logic                       tx_avail,
    input logic [7:0]                 line_stat,
    input logic                       flush,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    // R1: holding-empty in bit 5, the other bits stay zero
    p_empty_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stat[5] == !tx_avail) && (line_stat[7:6] == 2'b00) && (line_stat[4:0] == 5'd0));

    // R2, R3: in single mode the newest write is the pending byte
    p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !fifo_en && wr_en) |=> (flush || (tx_avail && tx_byte == $past(wr_data[7:0]))));

    // R4: a load with no write empties the single register
    p_single_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !fifo_en && ld_req && !wr_en) |=> (flush || !tx_avail));

    // R5: occupancy never exceeds the depth
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    // R5: a write to a full queue without a load leaves it full and the head unchanged
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && fifo_en && wr_en && !ld_req && fifo_cnt == ($clog2(DEPTH+1))'(DEPTH))
        |=> (flush || (fifo_cnt == ($clog2(DEPTH+1))'(DEPTH) && $stable(tx_byte))));

    // R9: a mode-change edge leaves nothing pending
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !tx_avail);

    // R10: with no write and no load, the outputs hold
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !wr_en && !ld_req) |=> (flush || ($stable(tx_byte) && $stable(tx_avail))));
endmodule

bind uart_tx_hold thb_checker #(.DEPTH(DEPTH)) u_thb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ld_req    (ld_req),
    .tx_byte   (tx_byte),
    .tx_avail  (tx_avail),
    .line_stat (line_stat),
    .flush     (mode_flush),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/test_uart_tx_hold.sv
// Directed bench for uart_tx_hold: one task per scenario, each checking its own results.
module test_uart_tx_hold;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ld_req = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic [7:0]  line_stat;

    int n_chk = 0;
    int n_fail = 0;

    uart_tx_hold i_uart_tx_hold (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ld_req(ld_req),
        .tx_byte(tx_byte), .tx_avail(tx_avail), .line_stat(line_stat)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Check a pending byte: available, with holding-empty clear.
    task automatic chk_pending(input string req, input logic [7:0] exp);
        chk(req, int'(tx_avail), 1);
        chk(req, int'(tx_byte), int'(exp));
        chk(req, int'(line_stat), 32'h00);
    endtask

    task automatic chk_empty(input string req);
        chk(req, int'(tx_avail), 0);
        chk(req, int'(line_stat), 32'h20);
    endtask

    // One cycle of write, optionally with a load at the same edge.
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic with_ld);
        wr_addr = a; wr_data = d; wr_en = 1'b1; ld_req = with_ld;
        @(negedge clk);
        wr_en = 1'b0; ld_req = 1'b0;
    endtask

    task automatic tx_ld();
        ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0;
    endtask

    task automatic t_reset();
        chk_empty("R1 reset");
    endtask

    task automatic t_single();
        bus_wr(4'd0, 32'h0000_00A5, 1'b0);
        chk_pending("R2 single write", 8'hA5);
        bus_wr(4'd3, 32'h0000_003C, 1'b0);
        chk_pending("R3 overwrite", 8'h3C);
        tx_ld();
        chk_empty("R4 load empties");
        tx_ld();
        chk_empty("R10 load when empty");
        bus_wr(4'd1, 32'h0000_0011, 1'b0);
        bus_wr(4'd2, 32'h0000_0022, 1'b1);
        chk_pending("R4 write with load", 8'h22);
    endtask

    task automatic t_single_to_fifo();
        fifo_en = 1'b1;
        @(negedge clk);
        chk_empty("R9 flush to fifo");
        @(negedge clk);
        chk_empty("R9 still empty");
    endtask

    task automatic t_fifo_full();
        for (int i = 0; i < 16; i++)
            bus_wr(4'(i), {8'hC3, 8'h5A, 8'hFF, 8'(i * 7 + 1)}, 1'b0);
        chk_pending("R8 alias head", 8'd1);
        bus_wr(4'd15, 32'h0000_00EE, 1'b0);
        chk_pending("R5 full drop head", 8'd1);
        for (int i = 0; i < 16; i++) begin
            chk_pending("R6 order", 8'(i * 7 + 1));
            tx_ld();
        end
        chk_empty("R5 R7 dropped byte absent, empty after last");
        tx_ld();
        chk_empty("R10 fifo load when empty");
    endtask

    task automatic t_fifo_mixed();
        bus_wr(4'd4, 32'h0000_0061, 1'b0);
        bus_wr(4'd9, 32'h0000_0062, 1'b0);
        tx_ld();
        chk_pending("R6 head after pop", 8'h62);
        bus_wr(4'd0, 32'h0000_0063, 1'b1);
        chk_pending("R6 push and pop", 8'h63);
        tx_ld();
        chk_empty("R7 last taken");
    endtask

    task automatic t_fifo_to_single();
        bus_wr(4'd0, 32'h0000_0071, 1'b0);
        bus_wr(4'd0, 32'h0000_0072, 1'b0);
        fifo_en = 1'b0;
        wr_data = 32'h0000_0077; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk_empty("R9 flush ignores write");
        bus_wr(4'd7, 32'hFFFF_FF44, 1'b0);
        chk_pending("R8 upper bits ignored", 8'h44);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_single_to_fifo();
        t_fifo_full();
        t_fifo_mixed();
        t_fifo_to_single();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule